// File: doc/BRIEF.md
# Reduced Four-State Symbol Tracker

This block is a Moore state machine that consumes one two-bit symbol per clock and drives a single flag whose value is fixed by the current state alone. Its transition table began as a six-state machine. Two pairs of those states could not be told apart from outside, so the table was folded down to four states: P, Q, R and S. The flag is 1 in P and R, and 0 in Q and S.

The state is held in two binary-coded flip-flops. A synchronous, active-low reset returns the machine to P. The flag is decoded from the state register, so it changes only after a rising clock edge and holds steady for the rest of the cycle. To use the block, present a symbol before each rising edge and read the flag after that edge.

Top module: `rfsm_reduced4`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the machine enters state P whatever sym_in carries, so flag_out reads 1 after that edge. Symbols presented during reset leave no trace once reset is released.
- R2: From state P, the symbols 2'b00, 2'b01, 2'b10 and 2'b11 move the machine to P, Q, R and S respectively.
- R3: From state Q, the symbols 2'b00, 2'b01, 2'b10 and 2'b11 move the machine to P, S, Q and S respectively.
- R4: From state R, the symbols 2'b00, 2'b01, 2'b10 and 2'b11 move the machine to Q, S, R and P respectively.
- R5: From state S, the symbols 2'b00, 2'b01, 2'b10 and 2'b11 move the machine to Q, P, P and S respectively.
- R6: flag_out is 1 in states P and R and 0 in states Q and S. It depends only on the state, so it changes only when the state changes.
- R7: For any input sequence, flag_out matches, cycle by cycle, the output of the unreduced six-state table. That table uses states A through F with outputs 1,0,1,0,1,0. For symbols 00/01/10/11 its transitions are: A to A/B/C/D, B to A/D/B/F, C to B/D/C/E, D to B/A/E/F, E to A/B/C/F, F to B/E/A/F. A reset sends it to A.
- R8: Reset is synchronous. Pulling rst_n low between edges does not alter flag_out until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to state P |
| sym_in | input | 2 | Input symbol sampled at each rising edge |
| flag_out | output | 1 | Moore output decoded from the current state |

## Verification
The bench builds the block with its default symbol width of two bits, the only width the transition table is defined for. At that width all sixteen state/symbol pairs can be reached. A fixed vector walk exercises every one of those transitions exactly from reset. A long pseudo-random run with occasional resets then compares the flag against a six-state model of the unreduced table, so the merged states A/E and D/F are both visited by many different paths.

// File: rtl/rfsm_pkg.sv
// Shared definitions for the reduced four-state symbol tracker.
// Assumes a two-bit symbol and a binary state code of two bits.
package rfsm_pkg;

    localparam int SYM_W = 2;
    localparam int ST_W  = 2;

    // Binary state code; ST_P is the reset state.
    typedef enum logic [ST_W-1:0] {
        ST_P = 2'd0,
        ST_Q = 2'd1,
        ST_R = 2'd2,
        ST_S = 2'd3
    } state_t;

endpackage

// File: rtl/rfsm_next.sv
// Next-state table of the reduced machine.
// Purely combinational; assumes cur_st always holds one of the four codes.
module rfsm_next
    import rfsm_pkg::*;
#(
    parameter int SW = SYM_W
) (
    input  state_t        cur_st,
    input  logic [SW-1:0] sym,
    output state_t        nxt_st
);

    // Look up the successor for the present state and symbol.
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_P: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_P;
                    2'b01:   nxt_st = ST_Q;
                    2'b10:   nxt_st = ST_R;
                    default: nxt_st = ST_S;
                endcase
            end
            ST_Q: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_P;
                    2'b01:   nxt_st = ST_S;
                    2'b10:   nxt_st = ST_Q;
                    default: nxt_st = ST_S;
                endcase
            end
            ST_R: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_Q;
                    2'b01:   nxt_st = ST_S;
                    2'b10:   nxt_st = ST_R;
                    default: nxt_st = ST_P;
                endcase
            end
            default: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_Q;
                    2'b01:   nxt_st = ST_P;
                    2'b10:   nxt_st = ST_P;
                    default: nxt_st = ST_S;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rfsm_state_reg.sv
// State register with synchronous active-low reset to ST_P.
// Assumes rst_n is synchronous to clk.
module rfsm_state_reg
    import rfsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t d_st,
    output state_t q_st
);

    // Capture the next state, or the reset state, on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q_st <= ST_P;
        else        q_st <= d_st;
    end

endmodule

// File: rtl/rfsm_out_dec.sv
// Moore output decode: the flag is a function of the state only.
// Assumes the input comes straight from the state register.
module rfsm_out_dec
    import rfsm_pkg::*;
(
    input  state_t cur_st,
    output logic   flag
);

    // Map each state to its output value.
    always_comb begin
        unique case (cur_st)
            ST_P, ST_R: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/rfsm_reduced4.sv
// Top of the reduced four-state symbol tracker.
// Connects the next-state table, the state register and the output decode.
// Assumes one symbol per clock and a synchronous active-low reset.
module rfsm_reduced4
    import rfsm_pkg::*;
#(
    parameter int SW = SYM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sym_in,
    output logic          flag_out
);

    state_t state_q;
    state_t state_d;

    rfsm_next #(.SW(SW)) u_next (
        .cur_st (state_q),
        .sym    (sym_in),
        .nxt_st (state_d)
    );

    rfsm_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_st  (state_d),
        .q_st  (state_q)
    );

    rfsm_out_dec u_dec (
        .cur_st (state_q),
        .flag   (flag_out)
    );

endmodule

// File: rtl/rfsm_reduced4_chk.sv
// Assertion checker for rfsm_reduced4, attached by bind below.
// Observes the ports and the state register; drives nothing.
module rfsm_reduced4_chk
    import rfsm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sym_in,
    input state_t     state_q,
    input logic       flag_out
);

    // R1 and R8: a low reset sampled at an edge lands in P after that edge.
    a_r1_reset_to_p: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_P && flag_out));

    // R2: successors of P.
    a_r2_from_p: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P) |=> state_q ==
            (($past(sym_in) == 2'b00) ? ST_P :
             ($past(sym_in) == 2'b01) ? ST_Q :
             ($past(sym_in) == 2'b10) ? ST_R : ST_S));

    // R3: successors of Q.
    a_r3_from_q: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Q) |=> state_q ==
            (($past(sym_in) == 2'b00) ? ST_P :
             ($past(sym_in) == 2'b10) ? ST_Q : ST_S));

    // R4: successors of R.
    a_r4_from_r: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_R) |=> state_q ==
            (($past(sym_in) == 2'b00) ? ST_Q :
             ($past(sym_in) == 2'b01) ? ST_S :
             ($past(sym_in) == 2'b10) ? ST_R : ST_P));

    // R5: successors of S.
    a_r5_from_s: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S) |=> state_q ==
            (($past(sym_in) == 2'b00) ? ST_Q :
             ($past(sym_in) == 2'b11) ? ST_S : ST_P));

    // R6: a raised flag only in P or R, a low flag only in Q or S.
    a_r6_flag_states: assert property (@(posedge clk) disable iff (!rst_n)
        flag_out |-> (state_q == ST_P || state_q == ST_R));

    a_r6_noflag_states: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_out |-> (state_q == ST_Q || state_q == ST_S));

    // R6: the flag holds while the state holds.
    a_r6_moore_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q) |-> $stable(flag_out));

endmodule

bind rfsm_reduced4 rfsm_reduced4_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_in   (sym_in),
    .state_q  (state_q),
    .flag_out (flag_out)
);

// File: tb/rfsm_reduced4_test.sv
// Self-checking bench: vector walk, reset corners, then a random comparison
// against a model of the unreduced six-state table.
module rfsm_reduced4_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sym_in = 2'b00;
    logic       flag_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rfsm_reduced4 uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_in   (sym_in),
        .flag_out (flag_out)
    );

    // Vectors {symbol, expected flag after the edge}, walked from reset;
    // together they cover all sixteen state/symbol pairs (R2..R6).
    localparam logic [2:0] VEC [19] = '{
        3'b00_1, 3'b01_0, 3'b00_1, 3'b10_1, 3'b00_0, 3'b10_0, 3'b01_0,
        3'b00_0, 3'b11_0, 3'b01_1, 3'b11_0, 3'b10_1, 3'b10_1, 3'b10_1,
        3'b01_0, 3'b11_0, 3'b10_1, 3'b10_1, 3'b11_1
    };

    // Six-state reference: 0..5 stand for A..F.
    int ref_st = 0;

    function automatic int ref_next(input int s, input logic [1:0] x);
        case (s)
            0: ref_next = (x == 2'b00) ? 0 : (x == 2'b01) ? 1 : (x == 2'b10) ? 2 : 3;
            1: ref_next = (x == 2'b00) ? 0 : (x == 2'b01) ? 3 : (x == 2'b10) ? 1 : 5;
            2: ref_next = (x == 2'b00) ? 1 : (x == 2'b01) ? 3 : (x == 2'b10) ? 2 : 4;
            3: ref_next = (x == 2'b00) ? 1 : (x == 2'b01) ? 0 : (x == 2'b10) ? 4 : 5;
            4: ref_next = (x == 2'b00) ? 0 : (x == 2'b01) ? 1 : (x == 2'b10) ? 2 : 5;
            default: ref_next = (x == 2'b00) ? 1 : (x == 2'b01) ? 4 : (x == 2'b10) ? 0 : 5;
        endcase
    endfunction

    function automatic logic ref_out(input int s);
        ref_out = (s == 0 || s == 2 || s == 4);
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: flag_out=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One clock: present a symbol at the falling edge, return at the next one.
    task automatic step(input logic [1:0] s);
        sym_in = s;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) ref_st = 0;
        else        ref_st = ref_next(ref_st, s);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2'b11);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        do_reset();
        check(flag_out, 1'b1, "R1 reset state");

        // Vector walk covering every transition of the reduced table.
        for (int k = 0; k < 19; k++) begin
            step(VEC[k][2:1]);
            check(flag_out, VEC[k][0], "R2-R6 vector walk");
        end

        // R1: reset from S (flag 0) while applying a symbol that keeps S.
        step(2'b01); step(2'b11);
        check(flag_out, 1'b0, "R5 reach S");
        rst_n = 1'b0;
        step(2'b11);
        check(flag_out, 1'b1, "R1 reset overrides symbol");
        step(2'b10);
        step(2'b01);
        check(flag_out, 1'b1, "R1 held reset ignores symbols");
        rst_n = 1'b1;
        step(2'b00);
        check(flag_out, 1'b1, "R1 released into P (00 keeps P)");

        // R8: reset pulled low mid-cycle does not act before the edge.
        step(2'b01);
        check(flag_out, 1'b0, "R8 in Q before reset");
        sym_in = 2'b10;
        #2;
        rst_n = 1'b0;
        #1;
        check(flag_out, 1'b0, "R8 no change before edge");
        @(posedge clk);
        @(negedge clk);
        check(flag_out, 1'b1, "R8 reset acts at edge");
        rst_n = 1'b1;
        ref_st = 0;

        // R7: random symbols against the six-state reference model.
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf ^= lf << 7;
            lf ^= lf >> 9;
            lf ^= lf << 8;
            rst_n = (lf[15:10] != 6'd0);
            step(lf[1:0]);
            check(flag_out, ref_out(ref_st), "R7 matches six-state table");
        end
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule